// File: doc/BRIEF.md
# Two-Window Watchdog Timer

This block supervises software through two counting phases that follow each other. After it is enabled it first counts a "closed" phase, during which software must not service it. When that phase runs out, an interrupt is raised and an "open" phase begins. Software must service the timer within the open phase. If the open phase runs out without service, a reset request is raised and held.

Servicing is a two-step handshake on a window-switch bit. First the bit is written as 0, then it is written as 1. Both writes go to the control/status register, and each one must follow a write to a single-use unlock register. A successful service starts the sequence again at the closed phase. An attempt to service during the closed phase counts as a fault and raises the reset request at once. Stopping the timer and changing the window lengths are honoured only while the timer is idle or in the open phase.

The register port is a plain 32-bit single-cycle port. Write data is captured on the clock edge where `bus_sel` and `bus_wr` are both high. Read data depends only on `bus_addr`, with no wait states.

Top module: `winwd_top`

## Requirements
- R1: After reset, every register (0x00, 0x04, 0x08, 0x0C, 0x10) reads 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: A write to the control/status register 0x04 has no effect unless it was preceded by a write of 1 in bit 0 of the unlock register 0x00.
- R3: The unlock is single-use. Register 0x00 bit 0 reads 1 after an unlock write and reads 0 after any write to 0x04.
- R4: An unlocked write to 0x04 with bit 0 = 1 while idle starts the closed phase, loading the length held in 0x0C. `irq_o` and status bit 16 rise on the L1-th clock edge after the starting write, where L1 is that length.
- R5: Register 0x04 reads bit 0 = 1 while the timer is counting (closed or open phase). Bit 8 reads 1 in the open phase and 0 otherwise. Bit 16 reads the interrupt flag.
- R6: The open phase loads the length held in 0x10. If it is not serviced, `wdt_rst_o` rises on the L2-th edge after the open phase begins, where L2 is that length. It then stays high until the block's reset, ignoring all writes.
- R7: An unlocked write to 0x04 with bit 16 = 1 clears the interrupt flag and `irq_o`.
- R8: In the open phase, the service sequence restarts the closed phase. The sequence is an unlocked write of 0x04 with bit 0 = 1 and bit 8 = 0, followed by an unlocked write with bits 0 and 8 both 1. A bit-8 = 1 write with no preceding bit-8 = 0 write does not restart.
- R9: In the closed phase, an unlocked write to 0x04 with bit 8 = 0 is a fault and raises `wdt_rst_o` on that write's clock edge.
- R10: An unlocked write to 0x04 with bit 0 = 0 stops the timer only in the open phase. The timer then stays idle and never raises reset. The same write with bit 8 = 1 in the closed phase is ignored.
- R11: Writes to 0x08 (function control, 32-bit storage), 0x0C and 0x10 take effect when idle or in the open phase, and are ignored in the closed phase.
- R12: With a first-phase length of 0, starting enters the open phase directly (0x04 bit 8 reads 1), no interrupt is raised, and reset follows L2 edges after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Closed-phase expiry interrupt, level |
| wdt_rst_o | output | 1 | Sticky reset request |

## Verification
A corrupted phase or counter shows up at the ports within one phase length. It appears as `irq_o` or `wdt_rst_o` moving one edge early or late, or as bit 8 of 0x04 reading the wrong phase in the same cycle. A lost or stuck unlock shows up on the next control write, either as a start that did not happen or as a fault that did not trip. A handshake flag that is not cleared lets a lone bit-8 = 1 write restart the timer. That is visible at once, because bit 8 of 0x04 drops to 0.

// File: rtl/winwd_pkg.sv
package winwd_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] ADR_KEY  = 5'h00;
    localparam logic [REG_AW-1:0] ADR_CTRL = 5'h04;
    localparam logic [REG_AW-1:0] ADR_FCTL = 5'h08;
    localparam logic [REG_AW-1:0] ADR_WIN1 = 5'h0C;
    localparam logic [REG_AW-1:0] ADR_WIN2 = 5'h10;

    localparam int BIT_EN  = 0;
    localparam int BIT_SW  = 8;
    localparam int BIT_INT = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLOSED = 2'd1,
        ST_OPEN   = 2'd2,
        ST_TRIP   = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic refresh;
        logic violate;
        logic int_clr;
    } wd_cmd_t;

    function automatic logic is_counting(wd_state_e s);
        return (s == ST_CLOSED) || (s == ST_OPEN);
    endfunction

    function automatic logic cfg_writable(wd_state_e s);
        return (s == ST_IDLE) || (s == ST_OPEN);
    endfunction

endpackage

// File: rtl/winwd_regs.sv
module winwd_regs
    import winwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  wd_state_e            st,
    input  logic                 int_flag,
    output logic [31:0]          bus_rdata,
    output wd_cmd_t              cmd,
    output logic [CNT_W-1:0]     len1,
    output logic [CNT_W-1:0]     len2,
    output logic                 unlock_o
);

    logic             unlock_q;
    logic             armed_q;
    logic [31:0]      fctl_q;
    logic [CNT_W-1:0] len1_q;
    logic [CNT_W-1:0] len2_q;
    logic             wr_any;
    logic             ctrl_wr;
    logic             ctrl_eff;
    logic             arm;
    logic             cfg_ok;

    assign wr_any   = bus_sel & bus_wr;
    assign ctrl_wr  = wr_any && (bus_addr == ADR_CTRL);
    assign ctrl_eff = ctrl_wr & unlock_q;
    assign cfg_ok   = wr_any & cfg_writable(st);

    // Command decode: what an effective control write means in each phase
    always_comb begin
        cmd         = '0;
        arm         = 1'b0;
        cmd.int_clr = ctrl_eff & bus_wdata[BIT_INT];
        case (st)
            ST_IDLE:   cmd.start   = ctrl_eff & bus_wdata[BIT_EN];
            ST_CLOSED: cmd.violate = ctrl_eff & ~bus_wdata[BIT_SW];
            ST_OPEN: begin
                cmd.stop    = ctrl_eff & ~bus_wdata[BIT_EN];
                arm         = ctrl_eff & bus_wdata[BIT_EN] & ~bus_wdata[BIT_SW];
                cmd.refresh = ctrl_eff & bus_wdata[BIT_EN] & bus_wdata[BIT_SW] & armed_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= 1'b0;
            armed_q  <= 1'b0;
            fctl_q   <= '0;
            len1_q   <= '0;
            len2_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                unlock_q <= 1'b0;
            end else if (wr_any && (bus_addr == ADR_KEY)) begin
                unlock_q <= bus_wdata[0];
            end

            if ((st != ST_OPEN) || cmd.refresh || cmd.stop) begin
                armed_q <= 1'b0;
            end else if (arm) begin
                armed_q <= 1'b1;
            end

            if (cfg_ok && (bus_addr == ADR_FCTL)) fctl_q <= bus_wdata;
            if (cfg_ok && (bus_addr == ADR_WIN1)) len1_q <= bus_wdata[CNT_W-1:0];
            if (cfg_ok && (bus_addr == ADR_WIN2)) len2_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_KEY:  bus_rdata[0] = unlock_q;
            ADR_CTRL: begin
                bus_rdata[BIT_EN]  = is_counting(st);
                bus_rdata[BIT_SW]  = (st == ST_OPEN);
                bus_rdata[BIT_INT] = int_flag;
            end
            ADR_FCTL: bus_rdata = fctl_q;
            ADR_WIN1: bus_rdata = 32'(len1_q);
            ADR_WIN2: bus_rdata = 32'(len2_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign len1     = len1_q;
    assign len2     = len2_q;
    assign unlock_o = unlock_q;

endmodule

// File: rtl/winwd_core.sv
module winwd_core
    import winwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wd_cmd_t          cmd,
    input  logic [CNT_W-1:0] len1,
    input  logic [CNT_W-1:0] len2,
    output wd_state_e        st,
    output logic             int_flag,
    output logic             tripped
);

    wd_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             int_q;
    logic             last;
    logic             skip_closed;

    assign last        = (cnt_q <= CNT_W'(1));
    assign skip_closed = (len1 == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            int_q <= 1'b0;
        end else begin
            if (cmd.int_clr) int_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cmd.start) begin
                        st_q  <= skip_closed ? ST_OPEN : ST_CLOSED;
                        cnt_q <= skip_closed ? len2 : len1;
                    end
                end
                ST_CLOSED: begin
                    if (cmd.violate) begin
                        st_q <= ST_TRIP;
                    end else if (last) begin
                        st_q  <= ST_OPEN;
                        cnt_q <= len2;
                        int_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_OPEN: begin
                    if (cmd.stop) begin
                        st_q <= ST_IDLE;
                    end else if (cmd.refresh) begin
                        st_q  <= skip_closed ? ST_OPEN : ST_CLOSED;
                        cnt_q <= skip_closed ? len2 : len1;
                    end else if (last) begin
                        st_q <= ST_TRIP;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign st       = st_q;
    assign int_flag = int_q;
    assign tripped  = (st_q == ST_TRIP);

endmodule

// File: rtl/winwd_top.sv
module winwd_top
    import winwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    wd_state_e        st;
    wd_cmd_t          cmd;
    logic [CNT_W-1:0] len1;
    logic [CNT_W-1:0] len2;
    logic             int_flag;
    logic             unlock;

    winwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .st        (st),
        .int_flag  (int_flag),
        .bus_rdata (bus_rdata),
        .cmd       (cmd),
        .len1      (len1),
        .len2      (len2),
        .unlock_o  (unlock)
    );

    winwd_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .len1     (len1),
        .len2     (len2),
        .st       (st),
        .int_flag (int_flag),
        .tripped  (wdt_rst_o)
    );

    assign irq_o = int_flag;

endmodule

// File: rtl/winwd_chk.sv
module winwd_chk
    import winwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic              wsw,
    input logic              unlock,
    input wd_state_e         st,
    input logic              irq_o,
    input logic              wdt_rst_o,
    input logic [CNT_W-1:0]  len1
);

    logic ctrl_wr;
    logic cfg_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
    assign cfg_wr  = bus_sel && bus_wr && (bus_addr == ADR_WIN1);

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> wdt_rst_o); // R6

    AST_LOCKED_CTRL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !unlock && st == ST_IDLE) |=> (st == ST_IDLE)); // R2

    AST_UNLOCK_SPENT: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !unlock); // R3

    AST_CLOSED_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && unlock && !wsw && st == ST_CLOSED) |=> wdt_rst_o); // R9

    AST_NO_STOP_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && unlock && wsw && st == ST_CLOSED) |=> (st != ST_IDLE)); // R10

    AST_CLOSED_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && st == ST_CLOSED) |=> $stable(len1)); // R11

    AST_IRQ_FROM_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(st) == ST_CLOSED)); // R4

endmodule

bind winwd_top winwd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wsw       (bus_wdata[8]),
    .unlock    (unlock),
    .st        (st),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o),
    .len1      (len1)
);

// File: tb/sim_winwd_top.sv
module sim_winwd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    winwd_top #(.CNT_W(32)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ulk_ctrl(input logic [31:0] d);
        wr(5'h00, 32'h1);
        wr(5'h04, d);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        waitn(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        hw_reset();
        rd(5'h00, d); check("R1 key", d, 0);
        rd(5'h04, d); check("R1 ctrl", d, 0);
        rd(5'h08, d); check("R1 fctl", d, 0);
        rd(5'h0C, d); check("R1 win1", d, 0);
        rd(5'h10, d); check("R1 win2", d, 0);
        check("R1 irq", irq_o, 0);
        check("R1 rst", wdt_rst_o, 0);
    endtask

    task automatic t_unlock();
        logic [31:0] d;
        hw_reset();
        wr(5'h0C, 10); wr(5'h10, 10);
        wr(5'h04, 32'h1);
        rd(5'h04, d); check("R2 locked start ignored", d, 0);
        wr(5'h00, 32'h1);
        rd(5'h00, d); check("R3 unlock set", d, 1);
        wr(5'h04, 32'h1);
        rd(5'h00, d); check("R3 unlock consumed", d, 0);
        rd(5'h04, d); check("R2 unlocked start", d, 32'h1);
        wr(5'h04, 32'h0);
        check("R2 locked clear no fault", wdt_rst_o, 0);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        hw_reset();
        wr(5'h0C, 5); wr(5'h10, 6);
        ulk_ctrl(32'h1);
        rd(5'h04, d); check("R5 closed readback", d, 32'h1);
        waitn(4); check("R4 irq before L1", irq_o, 0);
        waitn(1); check("R4 irq at L1", irq_o, 1);
        rd(5'h04, d); check("R5 open readback", d, 32'h10101);
        waitn(5); check("R6 no reset before L2", wdt_rst_o, 0);
        waitn(1); check("R6 reset at L2", wdt_rst_o, 1);
        ulk_ctrl(32'h0);
        waitn(5); check("R6 reset sticky", wdt_rst_o, 1);
        hw_reset();
        check("R1 reset clears trip", wdt_rst_o, 0);
        rd(5'h04, d); check("R1 ctrl after trip reset", d, 0);
    endtask

    task automatic t_refresh();
        logic [31:0] d;
        hw_reset();
        wr(5'h0C, 4); wr(5'h10, 20);
        ulk_ctrl(32'h1);
        waitn(4); check("R4 irq open", irq_o, 1);
        ulk_ctrl(32'h10101);
        check("R7 irq cleared", irq_o, 0);
        rd(5'h04, d); check("R7 status bit16 cleared", d, 32'h101);
        ulk_ctrl(32'h101);
        rd(5'h04, d); check("R8 lone set no restart", d, 32'h101);
        ulk_ctrl(32'h001);
        rd(5'h04, d); check("R8 clear step stays open", d, 32'h101);
        ulk_ctrl(32'h101);
        rd(5'h04, d); check("R8 refresh restarts closed", d, 32'h1);
        waitn(3); check("R8 irq not yet", irq_o, 0);
        waitn(1); check("R8 irq after new closed", irq_o, 1);
        check("R8 no reset", wdt_rst_o, 0);
    endtask

    task automatic t_violation();
        hw_reset();
        wr(5'h0C, 50); wr(5'h10, 50);
        ulk_ctrl(32'h1);
        check("R9 no reset yet", wdt_rst_o, 0);
        ulk_ctrl(32'h0);
        check("R9 closed refresh trips", wdt_rst_o, 1);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        hw_reset();
        wr(5'h0C, 6); wr(5'h10, 30);
        ulk_ctrl(32'h1);
        ulk_ctrl(32'h100);
        rd(5'h04, d); check("R10 stop ignored closed", d, 32'h1);
        check("R10 no fault on set write", wdt_rst_o, 0);
        waitn(6); check("R10 reached open", irq_o, 1);
        ulk_ctrl(32'h100);
        rd(5'h04, d); check("R10 stopped in open", d, 32'h10000);
        waitn(60); check("R10 idle no reset", wdt_rst_o, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        hw_reset();
        wr(5'h08, 32'hC0);
        rd(5'h08, d); check("R11 fctl idle write", d, 32'hC0);
        wr(5'h0C, 8); wr(5'h10, 40);
        rd(5'h0C, d); check("R11 win1 idle write", d, 8);
        ulk_ctrl(32'h1);
        wr(5'h0C, 3);
        rd(5'h0C, d); check("R11 win1 frozen closed", d, 8);
        wr(5'h08, 32'h55);
        rd(5'h08, d); check("R11 fctl frozen closed", d, 32'hC0);
        waitn(8); check("R11 reached open", irq_o, 1);
        wr(5'h0C, 3);
        rd(5'h0C, d); check("R11 win1 open write", d, 3);
    endtask

    task automatic t_zero_first();
        logic [31:0] d;
        hw_reset();
        wr(5'h10, 7);
        ulk_ctrl(32'h1);
        rd(5'h04, d); check("R12 starts open", d, 32'h101);
        check("R12 no irq", irq_o, 0);
        waitn(6); check("R12 no reset before L2", wdt_rst_o, 0);
        waitn(1); check("R12 reset at L2", wdt_rst_o, 1);
        check("R12 irq stays low", irq_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_unlock();
        t_timing();
        t_refresh();
        t_violation();
        t_stop();
        t_config();
        t_zero_first();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule